// File: doc/BRIEF.md
# Peripheral Register Bank for an 8-bit Processor Bus

This block is a small bank of six registers that hangs off an 8-bit processor bus with a 16-bit address, separate active-low read and write strobes, and an active-low request line. One parameter picks which request it answers: the I/O request (port-mapped use, the default) or the memory request (memory-mapped use). When the upper address bits match its base and the chosen request is low, the bank decodes the low address bits into one read select and one write select per register. It returns the selected register on the read data lines and raises a data-output-enable flag for as long as any read select is active.

The six registers have different side effects. Offset 0 is a plain control register. Offset 1 returns a status input. Offset 2 is a command register that also pulses a strobe after a write. Offset 3 returns an event input and pulses a strobe after a read. Offset 4 is a flag register: software sets its bits and hardware clears them. Offset 5 is a counter-style register that hardware can also load. Selects are level-sensitive, so a strobe repeats on every cycle that the bus access stays active.

Top module: `regbank_top`

## Requirements
- R1: On synchronous active-high reset, the control register takes CTL_DEF (0xA5), the command register CMD_DEF (0x00), the flag register FLAG_DEF (0x01) and the load register CNT_DEF (0x00). Both strobes go low and bus_doe is low while no access is made.
- R2: The bank is selected only when bus_addr[15:3] equals BASE_ADDR>>3 (BASE_ADDR = 0x0040, so registers sit at 0x0040..0x0045) and the chosen request is low. With USE_MEMREQ=0 that request is bus_ioreq_n. With the wrong address or with only bus_memreq_n low, a write changes no register and a read leaves bus_doe low.
- R3: bus_doe is 1 in exactly the cycles in which a register's read select is active. bus_rdata then carries that register zero-extended to 8 bits; otherwise it is 0. Offsets 6 and 7 have no register and leave bus_doe at 0.
- R4: A write to offset 0 makes ctl_q equal the written byte after the clock edge in which bus_wr_n is low. With no write, ctl_q holds.
- R5: A write to offset 2 stores the byte on cmd_q. cmd_stb is 1 for each clock that follows a cycle in which that write select was active, so a write held for N cycles gives N strobe cycles, followed by 0.
- R6: A read of offset 1 returns stat_i.
- R7: A read of offset 3 returns evt_i, zero-extended. evt_stb is 1 for the one clock after each cycle with that read select active, and 0 otherwise.
- R8: A write to offset 4 ORs the written bits into flag_q. A 1 on a flag_clr bit zeroes that bit at the next edge, and a clear beats a write that sets the same bit in the same cycle.
- R9: With cnt_ld high, cnt_q takes cnt_d at the next edge. A bus write to offset 5 in the same cycle wins over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, 0 when none is read |
| bus_doe | output | 1 | Read data valid, drive the data bus |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_ioreq_n | input | 1 | I/O request, active low |
| bus_memreq_n | input | 1 | Memory request, active low |
| ctl_q | output | 8 | Control register value |
| stat_i | input | 8 | Status input read at offset 1 |
| cmd_q | output | 8 | Command register value |
| cmd_stb | output | 1 | Pulse after a command write |
| evt_i | input | 4 | Event input read at offset 3 |
| evt_stb | output | 1 | Pulse after an event read |
| flag_q | output | 8 | Flag register value |
| flag_clr | input | 8 | Per-bit hardware clear of the flags |
| cnt_q | output | 6 | Loadable register value |
| cnt_ld | input | 1 | Hardware load enable |
| cnt_d | input | 6 | Hardware load data |

## Verification
Two pairs of actions can land in the same clock: a software write that sets a flag bit while hardware clears that same bit, and a bus write to the loadable register while the hardware load is high. The bench drives flag_clr and cnt_ld in the same cycle as the bus write strobe. It then judges from the register outputs that the clear won and that the bus data, not cnt_d, was stored. The bench also holds a command write over several cycles and checks that the strobe stays high through every one of them.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int NREG    = 6;
  localparam int IDX_CTL = 0;
  localparam int IDX_STA = 1;
  localparam int IDX_CMD = 2;
  localparam int IDX_EVT = 3;
  localparam int IDX_FLG = 4;
  localparam int IDX_CNT = 5;

  // which registers own a write select
  localparam logic [NREG-1:0] WRITABLE = 6'b110101;

  typedef enum logic {WM_LOAD, WM_OR} wmode_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int              ADDR_W   = 16,
  parameter int              NREG     = 6,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0040,
  parameter logic [NREG-1:0] WRITABLE = '1,
  localparam int             OFF_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              req_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [NREG-1:0]   rd_sel,
  output logic [NREG-1:0]   wr_sel
);
  logic blk_sel;

  assign blk_sel = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]) && !req_n;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    logic hit;
    assign hit       = blk_sel && (addr[OFF_W-1:0] == OFF_W'(i));
    assign rd_sel[i] = hit && !rd_n;
    if (WRITABLE[i]) begin : g_wr
      assign wr_sel[i] = hit && !wr_n;
    end else begin : g_ro
      assign wr_sel[i] = 1'b0;
    end
  end

  // R2: an idle request line never yields a select
  a_r2_no_req_no_sel: assert property (@(posedge clk) disable iff (rst)
    req_n |-> (rd_sel == '0 && wr_sel == '0));
  // R3: at most one register answers a read
  a_r3_rd_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel));
  a_r2_wr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
  import regbank_pkg::*;
#(
  parameter int          W    = 8,
  parameter wmode_e      MODE = WM_LOAD,
  parameter logic [W-1:0] DEF = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] clr,
  input  logic         ld,
  input  logic [W-1:0] ld_d,
  output logic [W-1:0] q
);
  logic [W-1:0] base_v;
  logic [W-1:0] nxt;

  always_comb begin
    base_v = ld ? ld_d : q;
    if (wr_sel) begin
      if (MODE == WM_OR) base_v = q | wdata;
      else               base_v = wdata;
    end
    nxt = base_v & ~clr;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= DEF;
    else     q <= nxt;
  end

  // R8: a cleared bit is zero after the edge, whatever else happened
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (|clr) |=> ((q & $past(clr)) == '0));
  // R4: with no write, load or clear the value holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_sel && !ld && clr == '0) |=> $stable(q));
  if (MODE == WM_LOAD) begin : g_ld_chk
    // R9: a bus write beats a simultaneous hardware load
    a_r9_write_over_load: assert property (@(posedge clk) disable iff (rst)
      wr_sel |=> (q == $past(wdata & ~clr)));
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int NREG   = 6,
  parameter int DATA_W = 8
) (
  input  logic [NREG-1:0]             rd_sel,
  input  logic [NREG-1:0][DATA_W-1:0] src,
  output logic [DATA_W-1:0]           rdata,
  output logic                        doe
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel[i]) rdata = src[i];
    end
    doe = |rd_sel;
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h0040,
  parameter bit                USE_MEMREQ = 1'b0,
  parameter int                CTL_W      = 8,
  parameter logic [CTL_W-1:0]  CTL_DEF    = 8'hA5,
  parameter int                STAT_W     = 8,
  parameter int                CMD_W      = 8,
  parameter logic [CMD_W-1:0]  CMD_DEF    = 8'h00,
  parameter int                EVT_W      = 4,
  parameter int                FLAG_W     = 8,
  parameter logic [FLAG_W-1:0] FLAG_DEF   = 8'h01,
  parameter int                CNT_W      = 6,
  parameter logic [CNT_W-1:0]  CNT_DEF    = 6'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_doe,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              bus_ioreq_n,
  input  logic              bus_memreq_n,
  output logic [CTL_W-1:0]  ctl_q,
  input  logic [STAT_W-1:0] stat_i,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              cmd_stb,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              evt_stb,
  output logic [FLAG_W-1:0] flag_q,
  input  logic [FLAG_W-1:0] flag_clr,
  output logic [CNT_W-1:0]  cnt_q,
  input  logic              cnt_ld,
  input  logic [CNT_W-1:0]  cnt_d
);
  logic                        req_n;
  logic [NREG-1:0]             rd_sel;
  logic [NREG-1:0]             wr_sel;
  logic [NREG-1:0][DATA_W-1:0] src;

  assign req_n = USE_MEMREQ ? bus_memreq_n : bus_ioreq_n;

  regbank_decode #(
    .ADDR_W(ADDR_W), .NREG(NREG), .BASE(BASE_ADDR), .WRITABLE(WRITABLE)
  ) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .req_n(req_n),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  regbank_cell #(.W(CTL_W), .MODE(WM_LOAD), .DEF(CTL_DEF)) u_ctl (
    .clk(clk), .rst(rst), .wr_sel(wr_sel[IDX_CTL]), .wdata(bus_wdata[CTL_W-1:0]),
    .clr('0), .ld(1'b0), .ld_d('0), .q(ctl_q)
  );

  regbank_cell #(.W(CMD_W), .MODE(WM_LOAD), .DEF(CMD_DEF)) u_cmd (
    .clk(clk), .rst(rst), .wr_sel(wr_sel[IDX_CMD]), .wdata(bus_wdata[CMD_W-1:0]),
    .clr('0), .ld(1'b0), .ld_d('0), .q(cmd_q)
  );

  regbank_cell #(.W(FLAG_W), .MODE(WM_OR), .DEF(FLAG_DEF)) u_flg (
    .clk(clk), .rst(rst), .wr_sel(wr_sel[IDX_FLG]), .wdata(bus_wdata[FLAG_W-1:0]),
    .clr(flag_clr), .ld(1'b0), .ld_d('0), .q(flag_q)
  );

  regbank_cell #(.W(CNT_W), .MODE(WM_LOAD), .DEF(CNT_DEF)) u_cnt (
    .clk(clk), .rst(rst), .wr_sel(wr_sel[IDX_CNT]), .wdata(bus_wdata[CNT_W-1:0]),
    .clr('0), .ld(cnt_ld), .ld_d(cnt_d), .q(cnt_q)
  );

  // one-cycle access strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_stb <= 1'b0;
      evt_stb <= 1'b0;
    end else begin
      cmd_stb <= wr_sel[IDX_CMD];
      evt_stb <= rd_sel[IDX_EVT];
    end
  end

  assign src[IDX_CTL] = DATA_W'(ctl_q);
  assign src[IDX_STA] = DATA_W'(stat_i);
  assign src[IDX_CMD] = DATA_W'(cmd_q);
  assign src[IDX_EVT] = DATA_W'(evt_i);
  assign src[IDX_FLG] = DATA_W'(flag_q);
  assign src[IDX_CNT] = DATA_W'(cnt_q);

  regbank_rdmux #(.NREG(NREG), .DATA_W(DATA_W)) u_mux (
    .rd_sel(rd_sel), .src(src), .rdata(bus_rdata), .doe(bus_doe)
  );

  // R5: a command write is followed by a strobe
  a_r5_cmd_stb: assert property (@(posedge clk) disable iff (rst)
    wr_sel[IDX_CMD] |=> cmd_stb);
  a_r5_cmd_stb_only: assert property (@(posedge clk) disable iff (rst)
    !wr_sel[IDX_CMD] |=> !cmd_stb);
  // R7: an event read is followed by a strobe
  a_r7_evt_stb: assert property (@(posedge clk) disable iff (rst)
    rd_sel[IDX_EVT] |=> evt_stb);
  // R3: nothing is driven without a read strobe
  a_r3_no_rd_no_doe: assert property (@(posedge clk) disable iff (rst)
    bus_rd_n |-> !bus_doe);
endmodule

// File: tb/regbank_tb_top.sv
`timescale 1ns/1ps
module regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_doe;
  logic        bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic        bus_ioreq_n = 1'b1, bus_memreq_n = 1'b1;
  logic [7:0]  ctl_q, cmd_q, flag_q;
  logic [7:0]  stat_i = '0, flag_clr = '0;
  logic        cmd_stb, evt_stb;
  logic [3:0]  evt_i = '0;
  logic [5:0]  cnt_q, cnt_d = '0;
  logic        cnt_ld = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  regbank_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_doe(bus_doe), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_ioreq_n(bus_ioreq_n), .bus_memreq_n(bus_memreq_n),
    .ctl_q(ctl_q), .stat_i(stat_i), .cmd_q(cmd_q), .cmd_stb(cmd_stb),
    .evt_i(evt_i), .evt_stb(evt_stb), .flag_q(flag_q), .flag_clr(flag_clr),
    .cnt_q(cnt_q), .cnt_ld(cnt_ld), .cnt_d(cnt_d)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one-cycle write; returns at the falling edge after the capturing edge
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit mem = 0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_n = 0;
    if (mem) bus_memreq_n = 0; else bus_ioreq_n = 0;
    @(negedge clk);
    bus_wr_n = 1; bus_ioreq_n = 1; bus_memreq_n = 1;
  endtask

  // one-cycle read; samples mid-cycle
  task automatic bus_read(input logic [15:0] a, output logic [7:0] d,
                          output logic oe, input bit mem = 0);
    @(negedge clk);
    bus_addr = a; bus_rd_n = 0;
    if (mem) bus_memreq_n = 0; else bus_ioreq_n = 0;
    #1; d = bus_rdata; oe = bus_doe;
    @(negedge clk);
    bus_rd_n = 1; bus_ioreq_n = 1; bus_memreq_n = 1;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe;
    chk("R1", "ctl_q", 16'(ctl_q), 16'hA5);
    chk("R1", "cmd_q", 16'(cmd_q), 16'h00);
    chk("R1", "flag_q", 16'(flag_q), 16'h01);
    chk("R1", "cnt_q", 16'(cnt_q), 16'h00);
    chk("R1", "strobes", {14'd0, cmd_stb, evt_stb}, 16'h0);
    chk("R1", "doe idle", 16'(bus_doe), 16'h0);
    bus_read(16'h0040, d, oe);
    chk("R3", "read ctl doe", 16'(oe), 16'h1);
    chk("R3", "read ctl data", 16'(d), 16'hA5);
  endtask

  task automatic t_select();
    logic [7:0] d; logic oe;
    bus_write(16'h0048, 8'h11);
    chk("R2", "other base ignored", 16'(ctl_q), 16'hA5);
    bus_write(16'h0040, 8'h22, 1);
    chk("R2", "memreq ignored", 16'(ctl_q), 16'hA5);
    bus_read(16'h0040, d, oe, 1);
    chk("R2", "memreq read doe", 16'(oe), 16'h0);
    bus_read(16'h1040, d, oe);
    chk("R2", "high addr read doe", 16'(oe), 16'h0);
    bus_read(16'h0046, d, oe);
    chk("R3", "offset 6 doe", 16'(oe), 16'h0);
    chk("R3", "offset 6 data", 16'(d), 16'h0);
    bus_read(16'h0047, d, oe);
    chk("R3", "offset 7 doe", 16'(oe), 16'h0);
  endtask

  task automatic t_config();
    logic [7:0] d; logic oe;
    bus_write(16'h0040, 8'h3C);
    chk("R4", "ctl written", 16'(ctl_q), 16'h3C);
    repeat (2) @(negedge clk);
    chk("R4", "ctl holds", 16'(ctl_q), 16'h3C);
    bus_read(16'h0040, d, oe);
    chk("R4", "ctl readback", 16'(d), 16'h3C);
  endtask

  task automatic t_status();
    logic [7:0] d; logic oe;
    stat_i = 8'h5A;
    bus_read(16'h0041, d, oe);
    chk("R6", "status read", 16'(d), 16'h5A);
    chk("R6", "status doe", 16'(oe), 16'h1);
    stat_i = 8'hC3;
    bus_read(16'h0041, d, oe);
    chk("R6", "status follows input", 16'(d), 16'hC3);
  endtask

  task automatic t_cmd_strobe();
    chk("R5", "stb idle", 16'(cmd_stb), 16'h0);
    bus_write(16'h0042, 8'h77);
    chk("R5", "cmd value", 16'(cmd_q), 16'h77);
    chk("R5", "stb after write", 16'(cmd_stb), 16'h1);
    @(negedge clk);
    chk("R5", "stb one cycle", 16'(cmd_stb), 16'h0);
    // write held for three cycles
    @(negedge clk);
    bus_addr = 16'h0042; bus_wdata = 8'h9E; bus_wr_n = 0; bus_ioreq_n = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5", "stb held write", 16'(cmd_stb), 16'h1);
    end
    bus_wr_n = 1; bus_ioreq_n = 1;
    @(negedge clk);
    chk("R5", "stb after held write", 16'(cmd_stb), 16'h0);
    chk("R5", "cmd held value", 16'(cmd_q), 16'h9E);
  endtask

  task automatic t_evt_strobe();
    logic [7:0] d; logic oe;
    evt_i = 4'hB;
    chk("R7", "stb idle", 16'(evt_stb), 16'h0);
    bus_read(16'h0043, d, oe);
    chk("R7", "event read zero-extended", 16'(d), 16'h0B);
    chk("R7", "stb after read", 16'(evt_stb), 16'h1);
    @(negedge clk);
    chk("R7", "stb one cycle", 16'(evt_stb), 16'h0);
    bus_write(16'h0043, 8'hFF);
    chk("R7", "write makes no read stb", 16'(evt_stb), 16'h0);
  endtask

  task automatic t_flags();
    bus_write(16'h0044, 8'h10);
    chk("R8", "or write 1", 16'(flag_q), 16'h11);
    bus_write(16'h0044, 8'h06);
    chk("R8", "or write 2", 16'(flag_q), 16'h17);
    @(negedge clk);
    flag_clr = 8'h01;
    @(negedge clk);
    flag_clr = 8'h00;
    chk("R8", "hw clear", 16'(flag_q), 16'h16);
    flag_clr = 8'h08;
    bus_write(16'h0044, 8'h88);
    flag_clr = 8'h00;
    chk("R8", "clear beats set", 16'(flag_q), 16'h96);
  endtask

  task automatic t_load();
    logic [7:0] d; logic oe;
    @(negedge clk);
    cnt_d = 6'h2A; cnt_ld = 1;
    @(negedge clk);
    cnt_ld = 0;
    chk("R9", "hw load", 16'(cnt_q), 16'h2A);
    cnt_d = 6'h3F; cnt_ld = 1;
    bus_write(16'h0045, 8'h15);
    cnt_ld = 0;
    chk("R9", "write beats load", 16'(cnt_q), 16'h15);
    bus_read(16'h0045, d, oe);
    chk("R9", "readback", 16'(d), 16'h15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_select();
    t_config();
    t_status();
    t_cmd_strobe();
    t_evt_strobe();
    t_flags();
    t_load();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule